// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each entry holds a virtual page number, a physical frame number, the address-space identifier of the process that installed it, and a valid bit. A lookup compares the requested page number against every entry at once. One cycle later the block reports either a hit, with the stored frame number, or a miss. A miss tells the surrounding logic that it must walk the page tables.

An external walker installs translations through the refill port. Each new entry is tagged with the identifier currently on the `cur_asid` input. The block has two build-time modes.
- With tagging enabled, an entry hits only while its tag equals `cur_asid`, so translations from several processes can live side by side.
- With tagging disabled, tags are ignored. Any change of `cur_asid` is treated as a context switch and empties the cache.

A flush strobe empties the cache in either mode.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is low, and the first lookup misses.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lkp_req` high, and low in every other cycle.
- R3: A lookup hits when some valid entry holds the requested page number and, in tagged mode, a tag equal to `cur_asid`. `rsp_pfn` then carries that entry's frame number.
- R4: In tagged mode, an entry whose tag differs from `cur_asid` does not hit. It hits again once `cur_asid` returns to its tag.
- R5: When no entry matches, `rsp_miss` is high, `rsp_hit` is low and `rsp_pfn` is zero. `rsp_hit` and `rsp_miss` are never high together.
- R6: A refill is written into the lowest-numbered invalid entry and is tagged with `cur_asid`. As a result, eight refills after a flush leave all eight translations present.
- R7: When every entry is valid, a refill replaces a round-robin victim. The victim starts at entry 0 after reset, advances by one for each such replacement, and wraps after the last entry.
- R8: A `flush` pulse invalidates all entries at the next clock edge.
- R9: A refill presented in the same cycle as a flush is discarded.
- R10: In untagged mode, tags take no part in matching. A change of `cur_asid` invalidates all entries at the next edge, and a refill in that cycle is discarded.
- R11: A lookup in the same cycle as a refill of the same page sees the contents from before the refill and misses. A lookup one cycle later hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_asid | input | ASID_W | Identifier of the running process |
| flush | input | 1 | Invalidate all entries |
| lkp_req | input | 1 | Lookup request |
| lkp_vpn | input | VPN_W | Page number to translate |
| fill_en | input | 1 | Refill write strobe from the walker |
| fill_vpn | input | VPN_W | Page number of the refill |
| fill_pfn | input | PFN_W | Frame number of the refill |
| rsp_valid | output | 1 | Lookup result present (one cycle after request) |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_miss | output | 1 | Lookup found none; a walk is needed |
| rsp_pfn | output | PFN_W | Translated frame number, zero on miss |

## Verification
Several functions can collide in one cycle. The main collision is a flush and a walker refill in the same cycle. The bench drives both strobes on the same clock edge. It then looks up the refilled page and expects a miss, which shows that the flush won.

The same approach covers a lookup that coincides with a refill. That lookup must report the old contents, and a second lookup one cycle later must hit. In the untagged instance, an identifier change arrives together with a refill. Both pages must then miss, while the tagged instance, fed the same stimulus, keeps the new refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_VPN_W   = 20;
  localparam int unsigned DEF_PFN_W   = 20;
  localparam int unsigned DEF_ASID_W  = 8;

  typedef enum logic {
    TAG_OFF = 1'b0,
    TAG_ON  = 1'b1
  } tag_mode_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N_ENT  = 8,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PFN_W  = 20,
  parameter int unsigned ASID_W = 8,
  parameter tlb_pkg::tag_mode_e MODE = tlb_pkg::TAG_ON
) (
  input  logic [N_ENT-1:0]             vld,
  input  logic [N_ENT-1:0][VPN_W-1:0]  vpn_tab,
  input  logic [N_ENT-1:0][PFN_W-1:0]  pfn_tab,
  input  logic [N_ENT-1:0][ASID_W-1:0] tag_tab,
  input  logic [VPN_W-1:0]             key_vpn,
  input  logic [ASID_W-1:0]            key_asid,
  output logic                         hit,
  output logic [PFN_W-1:0]             pfn
);
  logic [N_ENT-1:0] way_hit;

  for (genvar g = 0; g < N_ENT; g++) begin : g_way
    if (MODE == tlb_pkg::TAG_ON) begin : g_tag
      assign way_hit[g] = vld[g] && (vpn_tab[g] == key_vpn) && (tag_tab[g] == key_asid);
    end else begin : g_notag
      assign way_hit[g] = vld[g] && (vpn_tab[g] == key_vpn);
    end
  end

  // lowest index wins if several ways match
  always_comb begin
    hit = 1'b0;
    pfn = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (way_hit[i]) begin
        hit = 1'b1;
        pfn = pfn_tab[i];
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] vld,
  input  logic             adv,
  output logic [IDX_W-1:0] victim,
  output logic             all_vld
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  logic [IDX_W-1:0] rr_q, rr_d, free_idx;

  assign all_vld = &vld;

  always_comb begin
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim = all_vld ? rr_q : free_idx;

  always_comb begin
    rr_d = rr_q;
    if (adv) rr_d = (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rr_q <= '0;
    else if (adv) rr_q <= rr_d;
  end

  // R6: a free slot is chosen while one exists
  a_r6_victim_free: assert property (@(posedge clk) disable iff (!rst_n)
    !all_vld |-> !vld[victim]);

  // R7: replacement pointer moves by one, wrapping
  a_r7_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (rr_q == (($past(rr_q) == LAST) ? '0 : $past(rr_q) + 1'b1)));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int unsigned N_ENT  = tlb_pkg::DEF_ENTRIES,
  parameter int unsigned VPN_W  = tlb_pkg::DEF_VPN_W,
  parameter int unsigned PFN_W  = tlb_pkg::DEF_PFN_W,
  parameter int unsigned ASID_W = tlb_pkg::DEF_ASID_W,
  parameter tlb_pkg::tag_mode_e MODE = tlb_pkg::TAG_ON
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              flush,
  input  logic              lkp_req,
  input  logic [VPN_W-1:0]  lkp_vpn,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [PFN_W-1:0]  rsp_pfn
);
  localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [N_ENT-1:0]             vld_q, vld_d;
  logic [N_ENT-1:0][VPN_W-1:0]  vpn_q;
  logic [N_ENT-1:0][PFN_W-1:0]  pfn_q;
  logic [N_ENT-1:0][ASID_W-1:0] tag_q;

  logic              ctx_switch, wipe, fill_ok, rr_adv, all_vld;
  logic [IDX_W-1:0]  victim;
  logic              m_hit;
  logic [PFN_W-1:0]  m_pfn;
  logic              rv_q, rh_q;
  logic [PFN_W-1:0]  rp_q;

  // context switch detection only matters without tagging
  if (MODE == tlb_pkg::TAG_OFF) begin : g_ctx
    logic [ASID_W-1:0] prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur_asid;
    end
    assign ctx_switch = (cur_asid != prev_q);

    // R10: an identifier change empties the cache
    a_r10_ctx_wipe: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_asid != prev_q) |=> (vld_q == '0));
  end else begin : g_noctx
    assign ctx_switch = 1'b0;
  end

  assign wipe    = flush | ctx_switch;
  assign fill_ok = fill_en & ~wipe;
  assign rr_adv  = fill_ok & all_vld;

  tlb_victim #(.N_ENT(N_ENT)) u_victim (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld    (vld_q),
    .adv    (rr_adv),
    .victim (victim),
    .all_vld(all_vld)
  );

  tlb_match #(
    .N_ENT(N_ENT), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .MODE(MODE)
  ) u_match (
    .vld     (vld_q),
    .vpn_tab (vpn_q),
    .pfn_tab (pfn_q),
    .tag_tab (tag_q),
    .key_vpn (lkp_vpn),
    .key_asid(cur_asid),
    .hit     (m_hit),
    .pfn     (m_pfn)
  );

  // next-state for the valid vector
  always_comb begin
    vld_d = vld_q;
    if (wipe)         vld_d = '0;
    else if (fill_ok) vld_d[victim] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // entry payload, written only on an accepted refill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q <= '0;
      pfn_q <= '0;
      tag_q <= '0;
    end else if (fill_ok) begin
      vpn_q[victim] <= fill_vpn;
      pfn_q[victim] <= fill_pfn;
      tag_q[victim] <= cur_asid;
    end
  end

  // registered lookup response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rh_q <= 1'b0;
      rp_q <= '0;
    end else begin
      rv_q <= lkp_req;
      rh_q <= lkp_req & m_hit;
      rp_q <= (lkp_req & m_hit) ? m_pfn : '0;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_hit   = rh_q;
  assign rsp_miss  = rv_q & ~rh_q;
  assign rsp_pfn   = rp_q;

  // R2: response follows request by one cycle
  a_r2_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_req |=> !rsp_valid);

  // R5: hit and miss exclusive, miss carries zero frame
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss));
  a_r5_zero_pfn: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pfn == '0));

  // R8: flush clears all entries
  a_r8_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));

  // R9: a refill colliding with flush leaves nothing behind
  a_r9_fill_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fill_en) |=> ($countones(vld_q) == 0));
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb_top;
  localparam int unsigned VW = 20;
  localparam int unsigned PW = 20;
  localparam int unsigned AW = 8;

  logic          clk, rst_n;
  logic [AW-1:0] cur_asid;
  logic          flush, lkp_req, fill_en;
  logic [VW-1:0] lkp_vpn, fill_vpn;
  logic [PW-1:0] fill_pfn;
  logic          t_valid, t_hit, t_miss;
  logic [PW-1:0] t_pfn;
  logic          u_valid, u_hit, u_miss;
  logic [PW-1:0] u_pfn;

  int checks = 0;
  int errors = 0;

  asid_tlb #(.MODE(tlb_pkg::TAG_ON)) dut_i (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .flush(flush),
    .lkp_req(lkp_req), .lkp_vpn(lkp_vpn), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .rsp_valid(t_valid), .rsp_hit(t_hit), .rsp_miss(t_miss), .rsp_pfn(t_pfn));

  asid_tlb #(.MODE(tlb_pkg::TAG_OFF)) dut_na_i (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .flush(flush),
    .lkp_req(lkp_req), .lkp_vpn(lkp_vpn), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .rsp_valid(u_valid), .rsp_hit(u_hit), .rsp_miss(u_miss), .rsp_pfn(u_pfn));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [PW-1:0] pf(input logic [VW-1:0] v);
    return v ^ 20'h5A5A0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [VW-1:0] v, input bit with_flush);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_pfn = pf(v); flush = with_flush;
    @(negedge clk);
    fill_en = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  // lookup; outputs sampled one cycle after request
  task automatic look(input logic [VW-1:0] v);
    @(negedge clk); lkp_req = 1'b1; lkp_vpn = v;
    @(negedge clk); lkp_req = 1'b0;
  endtask

  task automatic expect_t(input logic [VW-1:0] v, input bit hit, input string req);
    look(v);
    chk(t_valid === 1'b1, req, {31'd0, t_valid}, 1);
    chk(t_hit === hit && t_miss === !hit, req, {31'd0, t_hit}, {31'd0, hit});
    chk(t_pfn === (hit ? pf(v) : '0), req, t_pfn, hit ? pf(v) : 0);
  endtask

  task automatic expect_u(input logic [VW-1:0] v, input bit hit, input string req);
    look(v);
    chk(u_hit === hit && u_miss === !hit, req, {31'd0, u_hit}, {31'd0, hit});
    chk(u_pfn === (hit ? pf(v) : '0), req, u_pfn, hit ? pf(v) : 0);
  endtask

  task automatic t_reset();
    chk(t_valid === 1'b0 && u_valid === 1'b0, "R1", {31'd0, t_valid}, 0);
    expect_t(20'h00000, 1'b0, "R1");
    @(negedge clk);
    chk(t_valid === 1'b0, "R2", {31'd0, t_valid}, 0);
  endtask

  task automatic t_basic();
    fill(20'h00100, 1'b0);
    expect_t(20'h00100, 1'b1, "R3");
    expect_t(20'h00101, 1'b0, "R5");
    @(negedge clk);
    chk(t_valid === 1'b0, "R2", {31'd0, t_valid}, 0);
  endtask

  task automatic t_asid();
    @(negedge clk); cur_asid = 8'd6;
    expect_t(20'h00100, 1'b0, "R4");
    @(negedge clk); cur_asid = 8'd5;
    expect_t(20'h00100, 1'b1, "R4");
  endtask

  task automatic t_flush();
    do_flush();
    expect_t(20'h00100, 1'b0, "R8");
  endtask

  task automatic t_fill_flush();
    fill(20'h00150, 1'b1);
    expect_t(20'h00150, 1'b0, "R9");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    lkp_req = 1'b1; lkp_vpn = 20'h00180;
    fill_en = 1'b1; fill_vpn = 20'h00180; fill_pfn = pf(20'h00180);
    @(negedge clk);
    lkp_req = 1'b0; fill_en = 1'b0;
    chk(t_miss === 1'b1, "R11", {31'd0, t_miss}, 1);
    expect_t(20'h00180, 1'b1, "R11");
  endtask

  task automatic t_order();
    do_flush();
    for (int i = 0; i < 8; i++) fill(20'h00200 + VW'(i), 1'b0);
    for (int i = 0; i < 8; i++) expect_t(20'h00200 + VW'(i), 1'b1, "R6");
    fill(20'h00300, 1'b0);
    expect_t(20'h00200, 1'b0, "R7");
    expect_t(20'h00300, 1'b1, "R7");
    expect_t(20'h00201, 1'b1, "R7");
    fill(20'h00301, 1'b0);
    expect_t(20'h00201, 1'b0, "R7");
    expect_t(20'h00202, 1'b1, "R7");
  endtask

  task automatic t_notag();
    do_flush();
    @(negedge clk); cur_asid = 8'd10;
    @(negedge clk);
    fill(20'h00400, 1'b0);
    expect_u(20'h00400, 1'b1, "R10");
    @(negedge clk);
    cur_asid = 8'd11;
    fill_en = 1'b1; fill_vpn = 20'h00401; fill_pfn = pf(20'h00401);
    @(negedge clk); fill_en = 1'b0;
    expect_u(20'h00400, 1'b0, "R10");
    expect_u(20'h00401, 1'b0, "R10");
    expect_t(20'h00400, 1'b0, "R4");
    expect_t(20'h00401, 1'b1, "R6");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cur_asid = 8'd5; flush = 1'b0; lkp_req = 1'b0; fill_en = 1'b0;
    lkp_vpn = '0; fill_vpn = '0; fill_pfn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_asid();
    t_flush();
    t_fill_flush();
    t_same_cycle();
    t_order();
    t_notag();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule